// File: doc/BRIEF.md
# Open-Drain Serial Clock Baud Timer

This block generates the serial clock for a two-wire bus master that is built from general shift logic. A single 16-bit compare word configures it. The low byte is the reload value of a divider, and that value sets how many system clocks each SCL half-period lasts. The high byte is an edge budget. It fixes how many SCL transitions the whole multi-word transfer contains. The usual setting is eighteen transitions per word plus one.

The timer stays idle until its trigger is active. The trigger is normally the "transmit data loaded" flag of the transmit shifter. Once started, the timer toggles its open-drain output each time the divider expires, and it stops on its own when the budget is spent. The line is shared, so the timer compares the level it drives with the level it reads back. While a slave holds the line low, the divider is restarted, which stretches the clock. Two strobes are delayed by a fixed synchronizer depth, and the data shifters use them. One marks each rising SCL edge for transmit shifting. The other marks each falling SCL edge for receive sampling.

Top module: `scl_baud_timer`

## Requirements
- R1: During and after reset, `scl_oe_o` is 0 (line released), `busy_o` is 0 and both strobes are 0.
- R2: When the timer is idle and the trigger is active (`trig_i` XOR `TRIG_INVERT` equals 1), `busy_o` is 1 after the next clock edge, and `scl_oe_o` does not change at that edge.
- R3: While running and not stretched, `scl_oe_o` toggles every (reload+1) clock cycles. The first toggle comes (reload+1) cycles after the edge at which `busy_o` rose. The reload value is `cmp_i[7:0]`.
- R4: A low byte below `MIN_RELOAD` (default 2) is used as `MIN_RELOAD`, so no half-period is shorter than 3 cycles. This gives a fastest SCL of the system clock divided by 6.
- R5: A transfer makes exactly `cmp_i[15:8]`+1 toggles of `scl_oe_o`. `busy_o` falls at the same edge as the last toggle.
- R6: While idle, `scl_oe_o` keeps its last level, and the next transfer starts from that level. `scl_oe_o` = 1 pulls the line low. `scl_oe_o` = 0 releases it.
- R7: While running, any cycle in which `scl_oe_o` equals `scl_pin_i` restarts the divider. A slave that holds the line low for S cycles after a release therefore lengthens that half-period by S cycles.
- R8: `shift_o` pulses for one cycle `SYNC_STAGES` (default 2) cycles after each 1-to-0 change of `scl_oe_o`. `sample_o` pulses the same way after each 0-to-1 change. The two never pulse together.
- R9: The trigger is ignored while busy. If the trigger is still active when a transfer ends, `busy_o` is low for exactly one cycle and a new transfer starts.
- R10: The edge budget is captured at start. Changing `cmp_i[15:8]` during a transfer has no effect on its toggle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Start trigger (polarity set by `TRIG_INVERT`) |
| cmp_i | input | 16 | Compare word: [15:8] edge budget, [7:0] half-period reload |
| scl_pin_i | input | 1 | Level read back from the SCL line |
| scl_oe_o | output | 1 | Open-drain enable: 1 pulls SCL low, 0 releases it |
| busy_o | output | 1 | Transfer in progress |
| shift_o | output | 1 | Delayed strobe for each rising SCL edge |
| sample_o | output | 1 | Delayed strobe for each falling SCL edge |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a reload floor of 2, a two-stage strobe delay and an active-high trigger. With these values, low-byte settings of 0 and 1 fall under the floor and exercise the clamp. Small budgets reach both odd and even toggle counts, so a transfer can end with the line held low. The two-cycle delay also places each strobe well inside the shortest legal half-period. An open-drain line model in the bench can hold the line low after a chosen release to exercise stretching. Back-to-back retriggering and mid-transfer changes to the trigger and the budget byte are also driven.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // Control state of the timer: run state and the driven open-drain enable
    typedef struct packed {
        tmr_state_e st;
        logic       drv;
    } tmr_ctl_t;

endpackage

// File: rtl/scl_half_div.sv
// Half-period divider: counts down from the (clamped) reload value and
// reports expiry; restarts on load, on expiry and while stretched.
module scl_half_div #(
    parameter int W          = 8,
    parameter int MIN_RELOAD = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [W-1:0] lo_i,
    output logic         expire_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN_RELOAD);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_regs_t;

    div_regs_t    div_d, div_q;
    logic [W-1:0] reload;

    assign reload   = (lo_i < MIN_V) ? MIN_V : lo_i;
    assign expire_o = run_i && !restart_i && (div_q.cnt == '0);

    always_comb begin
        div_d = div_q;
        if (load_i || restart_i || expire_o) begin
            div_d.cnt = reload;
        end else if (run_i) begin
            div_d.cnt = div_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/scl_edge_budget.sv
// Edge budget counter: captured at start, decremented per SCL toggle.
module scl_edge_budget #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         step_i,
    output logic         last_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } budget_regs_t;

    budget_regs_t bud_d, bud_q;

    assign last_o = (bud_q.cnt == '0);

    always_comb begin
        bud_d = bud_q;
        if (load_i) begin
            bud_d.cnt = val_i;
        end else if (step_i && !last_o) begin
            bud_d.cnt = bud_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bud_q <= '0;
        end else begin
            bud_q <= bud_d;
        end
    end

endmodule

// File: rtl/scl_strobe_pipe.sv
// Delays the edge events by STAGES cycles past the edge where SCL changes.
module scl_strobe_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic fall_i,
    output logic shift_o,
    output logic sample_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] rise;
        logic [DEPTH-1:0] fall;
    } pipe_regs_t;

    pipe_regs_t       pipe_d, pipe_q;
    logic [DEPTH-1:0] rise_shift;
    logic [DEPTH-1:0] fall_shift;

    if (DEPTH == 1) begin : g_single
        assign rise_shift = rise_i;
        assign fall_shift = fall_i;
    end else begin : g_chain
        assign rise_shift = {pipe_q.rise[DEPTH-2:0], rise_i};
        assign fall_shift = {pipe_q.fall[DEPTH-2:0], fall_i};
    end

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.rise = rise_shift;
        pipe_d.fall = fall_shift;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign shift_o  = pipe_q.rise[DEPTH-1];
    assign sample_o = pipe_q.fall[DEPTH-1];

endmodule

// File: rtl/scl_baud_timer.sv
module scl_baud_timer
    import scl_tmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int MIN_RELOAD  = 2,
    parameter int SYNC_STAGES = 2,
    parameter bit TRIG_INVERT = 1'b0,
    localparam int CMP_W      = 2 * BYTE_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic [CMP_W-1:0] cmp_i,
    input  logic             scl_pin_i,
    output logic             scl_oe_o,
    output logic             busy_o,
    output logic             shift_o,
    output logic             sample_o
);
    tmr_ctl_t ctl_d, ctl_q;

    logic trig_act;
    logic running;
    logic start;
    logic stretch;
    logic expire;
    logic budget_last;
    logic rise_evt;
    logic fall_evt;

    assign trig_act = trig_i ^ TRIG_INVERT;
    assign running  = (ctl_q.st == TMR_RUN);
    assign start    = !running && trig_act;
    assign stretch  = running && (ctl_q.drv == scl_pin_i);

    scl_half_div #(
        .W         (BYTE_W),
        .MIN_RELOAD(MIN_RELOAD)
    ) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (start),
        .run_i    (running),
        .restart_i(stretch),
        .lo_i     (cmp_i[BYTE_W-1:0]),
        .expire_o (expire)
    );

    scl_edge_budget #(
        .W(BYTE_W)
    ) u_budget (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(start),
        .val_i (cmp_i[CMP_W-1:BYTE_W]),
        .step_i(expire),
        .last_o(budget_last)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.st = TMR_RUN;
        end
        if (expire) begin
            ctl_d.drv = ~ctl_q.drv;
            if (budget_last) begin
                ctl_d.st = TMR_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{st: TMR_IDLE, drv: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // A release of the line is a rising SCL edge, a pull is a falling one
    assign rise_evt = expire && ctl_q.drv;
    assign fall_evt = expire && !ctl_q.drv;

    scl_strobe_pipe #(
        .STAGES(SYNC_STAGES)
    ) u_strobe (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise_evt),
        .fall_i  (fall_evt),
        .shift_o (shift_o),
        .sample_o(sample_o)
    );

    assign scl_oe_o = ctl_q.drv;
    assign busy_o   = running;

endmodule

// File: rtl/scl_baud_timer_chk.sv
module scl_baud_timer_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic scl_pin_i,
    input logic scl_oe_o,
    input logic busy_o,
    input logic shift_o,
    input logic sample_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!busy_o && !scl_oe_o && !shift_o && !sample_o));

    // R2
    start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $stable(scl_oe_o));

    // R4
    min_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_oe_o != $past(scl_oe_o)) |=> $stable(scl_oe_o) ##1 $stable(scl_oe_o));

    // R5
    stop_on_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (scl_oe_o != $past(scl_oe_o)));

    // R6
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o)) |-> $stable(scl_oe_o));

    // R7
    stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (scl_oe_o == scl_pin_i)) |=> $stable(scl_oe_o));

    // R8
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(shift_o && sample_o));

    // R8
    shift_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_o |-> ($past(scl_oe_o, SYNC_STAGES + 1) && !$past(scl_oe_o, SYNC_STAGES)));

    // R8
    sample_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (!$past(scl_oe_o, SYNC_STAGES + 1) && $past(scl_oe_o, SYNC_STAGES)));

endmodule

bind scl_baud_timer scl_baud_timer_chk #(
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_pin_i(scl_pin_i),
    .scl_oe_o (scl_oe_o),
    .busy_o   (busy_o),
    .shift_o  (shift_o),
    .sample_o (sample_o)
);

// File: tb/scl_baud_timer_tb_top.sv
`timescale 1ns/1ps
module scl_baud_timer_tb_top;
    localparam int BW   = 8;
    localparam int MINR = 2;
    localparam int SYNC = 2;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig  = 1'b0;
    logic          hold  = 1'b0;
    logic [2*BW-1:0] cmp = '0;
    logic          scl_pin;
    logic          scl_oe, busy, shift, sample;

    // open-drain line: low when pulled by the timer or held by a slave
    assign scl_pin = ~scl_oe & ~hold;

    scl_baud_timer dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .trig_i   (trig),
        .cmp_i    (cmp),
        .scl_pin_i(scl_pin),
        .scl_oe_o (scl_oe),
        .busy_o   (busy),
        .shift_o  (shift),
        .sample_o (sample)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    int exp_q[$];
    int toggles = 0, releases = 0, pulls = 0;
    int shift_cnt = 0, sample_cnt = 0, strobe_err = 0;
    int stretch_rel = -1, stretch_len = 0, hold_left = 0;
    int last_stamp = 0;
    logic mdl_oe = 1'b0;
    logic busy_prev = 1'b0;
    logic [SYNC+1:0] hist = '0;
    string cur_req = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected half-periods and checks strobes
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                hist      = '0;
                busy_prev = 1'b0;
            end else begin
                hist = {hist[SYNC:0], scl_oe};
                if (hold) begin
                    hold_left--;
                    if (hold_left <= 0) hold = 1'b0;
                end
                if (busy && !busy_prev) last_stamp = cyc;
                if (hist[0] != hist[1]) begin
                    toggles++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_req, "unexpected toggle", cyc - last_stamp, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check((cyc - last_stamp) == e, cur_req, "half period",
                              cyc - last_stamp, e);
                    end
                    last_stamp = cyc;
                    if (!hist[0]) begin
                        releases++;
                        if (releases == stretch_rel) begin
                            hold      = 1'b1;
                            hold_left = stretch_len;
                        end
                    end else begin
                        pulls++;
                    end
                end
                if (shift !== (hist[SYNC+1] & ~hist[SYNC]) ||
                    sample !== (~hist[SYNC+1] & hist[SYNC])) strobe_err++;
                shift_cnt  += int'(shift);
                sample_cnt += int'(sample);
                busy_prev = busy;
            end
        end
    end

    // driver: pushes the expected half-periods, then runs one transfer
    task automatic xfer(input int lo, input int hi, input int reps, input int s_rel,
                        input int s_len, input bit disturb, input string req);
        int   eff, extra, rel, n;
        int   t0, r0, p0, sh0, sa0, se0;
        logic lvl;
        eff   = (lo < MINR) ? MINR : lo;
        extra = 0;
        rel   = 0;
        lvl   = mdl_oe;
        @(negedge clk);
        t0 = toggles; r0 = releases; p0 = pulls;
        sh0 = shift_cnt; sa0 = sample_cnt; se0 = strobe_err;
        stretch_rel = (s_rel > 0) ? releases + s_rel : -1;
        stretch_len = s_len;
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i <= hi; i++) begin
                exp_q.push_back(eff + 1 + extra);
                extra = 0;
                lvl = ~lvl;
                if (!lvl) begin
                    rel++;
                    if (rel == s_rel) extra = s_len;
                end
            end
        end
        cur_req = req;
        cmp  = {8'(hi), 8'(lo)};
        trig = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy after trigger", int'(busy), 1);
        check(scl_oe == mdl_oe, "R2", "level kept at start", int'(scl_oe), int'(mdl_oe));
        if (reps == 1) trig = 1'b0;
        for (int r = 0; r < reps; r++) begin
            n = 0;
            while (busy) begin
                @(negedge clk);
                n++;
                if (disturb && n == 4) begin
                    trig = 1'b1;
                    cmp[15:8] = 8'hF0;
                end
                if (disturb && n == 6) trig = 1'b0;
            end
            if (r + 1 < reps) begin
                check(busy == 1'b0, "R9", "gap before retrigger", int'(busy), 0);
                @(negedge clk);
                check(busy == 1'b1, "R9", "retrigger start", int'(busy), 1);
                if (r + 2 == reps) trig = 1'b0;
            end
        end
        mdl_oe = lvl;
        repeat (SYNC + 2) @(negedge clk);
        check((toggles - t0) == reps * (hi + 1), (reps > 1) ? "R9" : (disturb ? "R10" : "R5"),
              "toggle count", toggles - t0, reps * (hi + 1));
        check(exp_q.size() == 0, "R5", "leftover expected toggles", exp_q.size(), 0);
        check(scl_oe == mdl_oe, "R6", "final level", int'(scl_oe), int'(mdl_oe));
        check((strobe_err - se0) == 0, "R8", "strobe timing errors", strobe_err - se0, 0);
        check((shift_cnt - sh0) == (releases - r0), "R8", "shift strobes",
              shift_cnt - sh0, releases - r0);
        check((sample_cnt - sa0) == (pulls - p0), "R8", "sample strobes",
              sample_cnt - sa0, pulls - p0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_oe == 1'b0, "R1", "scl_oe in reset", int'(scl_oe), 0);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(shift == 1'b0 && sample == 1'b0, "R1", "strobes in reset",
              int'(shift) + int'(sample), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && scl_oe == 1'b0, "R1", "idle after reset",
              int'(busy) + int'(scl_oe), 0);

        xfer(3, 5, 1, 0, 0, 1'b0, "R3");          // plain transfer
        xfer(0, 3, 1, 0, 0, 1'b0, "R4");          // reload 0 clamped to 2
        xfer(1, 3, 1, 0, 0, 1'b0, "R4");          // reload 1 clamped to 2
        xfer(2, 7, 1, 2, 5, 1'b0, "R7");          // slave stretches 2nd release
        xfer(2, 2, 1, 0, 0, 1'b0, "R6");          // odd toggle count, ends pulled low
        repeat (8) @(negedge clk);
        check(scl_oe == 1'b1 && busy == 1'b0, "R6", "idle keeps pulled level",
              int'(scl_oe), 1);
        xfer(2, 2, 1, 0, 0, 1'b0, "R6");          // starts from the pulled level
        xfer(2, 3, 2, 0, 0, 1'b0, "R9");          // trigger held: back-to-back
        xfer(4, 5, 1, 0, 0, 1'b1, "R10");         // trigger and budget disturbed

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule